// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. After reset it owns the memory command bus and walks it through the power-up procedure the device requires. It holds clock enable low while power and clock settle, then raises it. It precharges all banks and loads the four mode registers in a fixed order, including a DLL reset. It precharges again, issues two refreshes, and finishes with an off-chip-driver calibration default/exit pair. Between commands it waits the time each step needs. Once the last wait expires it raises a completion flag and leaves the bus idle, so that the normal controller can take over.

Each wait is given as a parameter in nanoseconds. Elaboration converts it to a clock-cycle count by rounding up against a clock-period parameter. Software supplies the mode-register code words as inputs, and the sequencer forces the few fields that the procedure itself dictates. A second flag tells the downstream controller when reads are allowed. That requires the sequence to be complete and the DLL to have had its lock time since the DLL reset. The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, including a reset applied partway through the sequence, CKE and ODT are low, the bus carries NOP with BA and address all zero, and both flags are low.
- R2: ODT stays low at all times. CKE stays low for the power-up wait after reset release, then rises together with a NOP and never falls again.
- R3: The first PRECHARGE (address bit A10 = 1, every other address bit and BA zero) comes exactly the 400 ns wait after the CKE rise.
- R4: Mode loads use BA to select the register: 0 = MR, 1 = EMR, 2 = EMR(2), 3 = EMR(3). The first loads are EMR(2), then EMR(3), then EMR, each carrying its code word and each separated from the next command by the tMRD wait.
- R5: Every EMR load forces A0 = 0 (DLL enabled). The OCD field A9:A7 is 000 on the first EMR load, 111 on the OCD-default load and 000 on the OCD-exit load. All other bits come from the EMR code word.
- R6: The MR is loaded twice: first with A8 (DLL reset) forced to 1, then later with A8 forced to 0. All other bits come from the MR code word.
- R7: The tMRD wait after the DLL-reset load is followed by a second precharge-all. The tRPA wait after it is followed by two REFRESH commands (BA and address zero), each followed by the tRFC wait. The MR load with A8 = 0 comes next.
- R8: Command encoding on {CS#, RAS#, CAS#, WE#} is NOP 0111, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000. Each command lasts one cycle. Every other cycle is NOP with BA and address zero.
- R9: Each wait spans ceil(time_ns / period_ns) cycles from one command to the next, with a floor of 2 cycles.
- R10: init_done rises one tMRD wait after the OCD-exit load and stays high. After that the bus stays NOP with CKE high.
- R11: read_ok is high only once init_done is high and at least LOCK_CYC cycles have passed since the cycle that carried the DLL-reset load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_code | input | ROW_W | Code word for the mode register |
| emr_code | input | ROW_W | Code word for extended mode register 1 |
| emr2_code | input | ROW_W | Code word for extended mode register 2 |
| emr3_code | input | ROW_W | Code word for extended mode register 3 |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_odt | output | 1 | On-die termination control |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ROW_W | Address bus |
| init_done | output | 1 | Sequence complete, bus free |
| read_ok | output | 1 | Reads permitted (done and DLL lock time elapsed) |

## Verification
A step counter that is off by one shows up on the command bus as a missing, repeated or reordered command, or as a wrong BA. It becomes visible in the very cycle where the next command was due. A wait counter that loads a wrong value moves every later command. The first wrong cycle is the one where a command lands early or late, and that is at most one wait after the fault. A lock counter that starts at the wrong time, or compares wrongly, moves the rise of read_ok away from exactly LOCK_CYC cycles after the DLL-reset load.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  localparam int STEP_W   = 4;
  localparam int STEP_END = 12;

  // Cycles for a wait, rounded up, never below two.
  function automatic int ns_to_cyc(input int t_ns, input int tck_ns);
    int c;
    c = (t_ns + tck_ns - 1) / tck_ns;
    if (c < 2) c = 2;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr2i_gap_timer.sv
module ddr2i_gap_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2i_step_decode.sv
module ddr2i_step_decode
  import ddr2i_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int BA_W    = 3,
  parameter int CNT_W   = 8,
  parameter int RLD_CKE = 1,
  parameter int RLD_RPA = 1,
  parameter int RLD_MRD = 1,
  parameter int RLD_RFC = 1
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ROW_W-1:0]  mr_code_i,
  input  logic [ROW_W-1:0]  emr_code_i,
  input  logic [ROW_W-1:0]  emr2_code_i,
  input  logic [ROW_W-1:0]  emr3_code_i,
  output cmd_e              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              cke_on_o,
  output logic              dll_rst_o,
  output logic              last_o
);

  localparam int BIT_DLL_OFF = 0;
  localparam int BIT_DLL_RST = 8;
  localparam int BIT_AP      = 10;
  localparam int OCD_LO      = 7;

  function automatic logic [ROW_W-1:0] emr_word(input logic [ROW_W-1:0] code,
                                                input logic [2:0] ocd);
    logic [ROW_W-1:0] w;
    w = code;
    w[OCD_LO +: 3]  = ocd;
    w[BIT_DLL_OFF]  = 1'b0;
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] mr_word(input logic [ROW_W-1:0] code,
                                               input logic dll_rst);
    logic [ROW_W-1:0] w;
    w = code;
    w[BIT_DLL_RST] = dll_rst;
    return w;
  endfunction

  logic [ROW_W-1:0] ap_word;

  always_comb begin
    ap_word         = '0;
    ap_word[BIT_AP] = 1'b1;
  end

  always_comb begin
    cmd_o     = CMD_NOP;
    ba_o      = '0;
    addr_o    = '0;
    reload_o  = CNT_W'(RLD_MRD);
    cke_on_o  = 1'b0;
    dll_rst_o = 1'b0;
    last_o    = 1'b0;
    unique case (step_i)
      4'd0: begin
        cke_on_o = 1'b1;
        reload_o = CNT_W'(RLD_CKE);
      end
      4'd1, 4'd6: begin
        cmd_o    = CMD_PRE;
        addr_o   = ap_word;
        reload_o = CNT_W'(RLD_RPA);
      end
      4'd2: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(2'd2);
        addr_o = emr2_code_i;
      end
      4'd3: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(2'd3);
        addr_o = emr3_code_i;
      end
      4'd4, 4'd11: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(2'd1);
        addr_o = emr_word(emr_code_i, 3'b000);
      end
      4'd5: begin
        cmd_o     = CMD_LMR;
        addr_o    = mr_word(mr_code_i, 1'b1);
        dll_rst_o = 1'b1;
      end
      4'd7, 4'd8: begin
        cmd_o    = CMD_REF;
        reload_o = CNT_W'(RLD_RFC);
      end
      4'd9: begin
        cmd_o  = CMD_LMR;
        addr_o = mr_word(mr_code_i, 1'b0);
      end
      4'd10: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_W'(2'd1);
        addr_o = emr_word(emr_code_i, 3'b111);
      end
      default: begin
        last_o   = 1'b1;
        reload_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/ddr2i_lock_timer.sv
module ddr2i_lock_timer #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);

  generate
    if (LOCK_CYC <= 1) begin : g_short
      logic exp_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       exp_q <= 1'b0;
        else if (start_i) exp_q <= 1'b1;
      end
      assign expired_o = exp_q;
    end else begin : g_count
      localparam int LW = $clog2(LOCK_CYC);
      logic [LW-1:0] cnt_q, cnt_d;
      logic          run_q, run_d;
      logic          exp_q, exp_d;

      always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        exp_d = exp_q;
        if (start_i) begin
          cnt_d = LW'(LOCK_CYC - 1);
          run_d = 1'b1;
          exp_d = 1'b0;
        end else if (run_q) begin
          if (cnt_q == '0) begin
            run_d = 1'b0;
            exp_d = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          exp_q <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
          run_q <= run_d;
          exp_q <= exp_d;
        end
      end
      assign expired_o = exp_q;
    end
  endgenerate

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2i_pkg::*;
#(
  parameter int TCK_NS       = 3,
  parameter int T_POWERUP_NS = 200000,
  parameter int T_CKE_NS     = 400,
  parameter int T_RPA_NS     = 15,
  parameter int T_MRD_NS     = 6,
  parameter int T_RFC_NS     = 128,
  parameter int LOCK_CYC     = 200,
  parameter int ROW_W        = 14,
  parameter int BA_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] mr_code,
  input  logic [ROW_W-1:0] emr_code,
  input  logic [ROW_W-1:0] emr2_code,
  input  logic [ROW_W-1:0] emr3_code,
  output logic             ddr_cke,
  output logic             ddr_odt,
  output logic             ddr_cs_n,
  output logic             ddr_ras_n,
  output logic             ddr_cas_n,
  output logic             ddr_we_n,
  output logic [BA_W-1:0]  ddr_ba,
  output logic [ROW_W-1:0] ddr_addr,
  output logic             init_done,
  output logic             read_ok
);

  localparam int CYC_PWR = ns_to_cyc(T_POWERUP_NS, TCK_NS);
  localparam int CYC_CKE = ns_to_cyc(T_CKE_NS, TCK_NS);
  localparam int CYC_RPA = ns_to_cyc(T_RPA_NS, TCK_NS);
  localparam int CYC_MRD = ns_to_cyc(T_MRD_NS, TCK_NS);
  localparam int CYC_RFC = ns_to_cyc(T_RFC_NS, TCK_NS);
  localparam int CYC_MAX = max2(max2(CYC_PWR, CYC_CKE),
                                max2(max2(CYC_RPA, CYC_MRD), CYC_RFC));
  localparam int CNT_W   = $clog2(CYC_MAX);

  logic [STEP_W-1:0] step_q, step_d;
  logic              cke_q, cke_d;
  logic              done_q, done_d;
  cmd_e              cmd_q, cmd_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ROW_W-1:0]  addr_q, addr_d;

  logic              tmr_zero;
  logic              adv;
  cmd_e              dec_cmd;
  logic [BA_W-1:0]   dec_ba;
  logic [ROW_W-1:0]  dec_addr;
  logic [CNT_W-1:0]  dec_reload;
  logic              dec_cke_on;
  logic              dec_dll_rst;
  logic              dec_last;
  logic              lock_done;

  assign adv = tmr_zero & ~done_q;

  ddr2i_gap_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (CYC_PWR - 1)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (adv),
    .load_val_i (dec_reload),
    .zero_o     (tmr_zero)
  );

  ddr2i_step_decode #(
    .ROW_W   (ROW_W),
    .BA_W    (BA_W),
    .CNT_W   (CNT_W),
    .RLD_CKE (CYC_CKE - 1),
    .RLD_RPA (CYC_RPA - 1),
    .RLD_MRD (CYC_MRD - 1),
    .RLD_RFC (CYC_RFC - 1)
  ) u_dec (
    .step_i      (step_q),
    .mr_code_i   (mr_code),
    .emr_code_i  (emr_code),
    .emr2_code_i (emr2_code),
    .emr3_code_i (emr3_code),
    .cmd_o       (dec_cmd),
    .ba_o        (dec_ba),
    .addr_o      (dec_addr),
    .reload_o    (dec_reload),
    .cke_on_o    (dec_cke_on),
    .dll_rst_o   (dec_dll_rst),
    .last_o      (dec_last)
  );

  ddr2i_lock_timer #(
    .LOCK_CYC (LOCK_CYC)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (adv & dec_dll_rst),
    .expired_o (lock_done)
  );

  always_comb begin
    step_d = step_q;
    cke_d  = cke_q;
    done_d = done_q;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (adv) begin
      cmd_d  = dec_cmd;
      ba_d   = dec_ba;
      addr_d = dec_addr;
      if (dec_cke_on) cke_d = 1'b1;
      if (dec_last) begin
        done_d = 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (adv) begin
      step_q <= step_d;
      cke_q  <= cke_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign ddr_cke   = cke_q;
  assign ddr_odt   = 1'b0;
  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
  assign ddr_ba    = ba_q;
  assign ddr_addr  = addr_q;
  assign init_done = done_q;
  assign read_ok   = done_q & lock_done;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ddr_cke,
  input logic             ddr_odt,
  input logic             ddr_cs_n,
  input logic             ddr_ras_n,
  input logic             ddr_cas_n,
  input logic             ddr_we_n,
  input logic [BA_W-1:0]  ddr_ba,
  input logic [ROW_W-1:0] ddr_addr,
  input logic             init_done,
  input logic             read_ok
);

  logic [3:0] cmd;
  logic       is_nop;
  assign cmd    = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
  assign is_nop = (cmd == 4'b0111);

  p_odt_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_odt);

  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |=> ddr_cke);

  p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> ddr_cke);

  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> ddr_addr[10]);

  p_one_cycle_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);

  p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (ddr_ba == '0 && ddr_addr == '0));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (is_nop && ddr_cke));

  p_read_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> init_done);

  p_read_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |=> read_ok);

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .ROW_W (ROW_W),
  .BA_W  (BA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ddr_cke   (ddr_cke),
  .ddr_odt   (ddr_odt),
  .ddr_cs_n  (ddr_cs_n),
  .ddr_ras_n (ddr_ras_n),
  .ddr_cas_n (ddr_cas_n),
  .ddr_we_n  (ddr_we_n),
  .ddr_ba    (ddr_ba),
  .ddr_addr  (ddr_addr),
  .init_done (init_done),
  .read_ok   (read_ok)
);

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;

  localparam int TCK   = 10;
  localparam int T_PWR = 500;
  localparam int T_CKE = 400;
  localparam int T_RPA = 15;
  localparam int T_MRD = 5;
  localparam int T_RFC = 130;
  localparam int LOCK  = 200;
  localparam int ROW_W = 14;
  localparam int BA_W  = 3;

  logic clk;
  logic rst_n;
  logic [ROW_W-1:0] mr_code, emr_code, emr2_code, emr3_code;
  logic ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [BA_W-1:0]  ddr_ba;
  logic [ROW_W-1:0] ddr_addr;
  logic init_done, read_ok;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  ddr2_init_seq #(
    .TCK_NS       (TCK),
    .T_POWERUP_NS (T_PWR),
    .T_CKE_NS     (T_CKE),
    .T_RPA_NS     (T_RPA),
    .T_MRD_NS     (T_MRD),
    .T_RFC_NS     (T_RFC),
    .LOCK_CYC     (LOCK),
    .ROW_W        (ROW_W),
    .BA_W         (BA_W)
  ) u_ddr2_init_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mr_code   (mr_code),
    .emr_code  (emr_code),
    .emr2_code (emr2_code),
    .emr3_code (emr3_code),
    .ddr_cke   (ddr_cke),
    .ddr_odt   (ddr_odt),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .ddr_addr  (ddr_addr),
    .init_done (init_done),
    .read_ok   (read_ok)
  );

  // R9: ceil with a two-cycle floor
  function automatic int cyc_of(input int t);
    int c;
    c = t / TCK;
    if (c * TCK < t) c = c + 1;
    return (c < 2) ? 2 : c;
  endfunction

  int ev[13];
  int read_at;
  int last_n;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] pack(input logic [3:0] c, input logic [2:0] b,
                                       input logic [13:0] a);
    return {c, b, a};
  endfunction

  task automatic run(input logic [13:0] mr, input logic [13:0] emr,
                     input logic [13:0] e2, input logic [13:0] e3,
                     input int stop_at);
    logic [20:0] exp_bus;
    logic [20:0] act_bus;
    string tag;
    @(negedge clk);
    rst_n = 1'b0;
    mr_code = mr; emr_code = emr; emr2_code = e2; emr3_code = e3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ddr_cke && !ddr_odt, "R1 cke/odt in reset", {ddr_cke, ddr_odt}, 0);
    act_bus = pack({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, ddr_ba, ddr_addr);
    chk(act_bus == pack(4'b0111, 3'd0, 14'd0), "R1 bus in reset", act_bus,
        pack(4'b0111, 3'd0, 14'd0));
    chk(!init_done && !read_ok, "R1 flags in reset", {init_done, read_ok}, 0);
    rst_n = 1'b1;
    for (int n = 1; n <= last_n; n++) begin
      @(negedge clk);
      if (stop_at != 0 && n == stop_at) break;
      chk(ddr_odt == 1'b0, "R2 odt", ddr_odt, 0);
      chk(ddr_cke == (n >= ev[0]), "R2 cke", ddr_cke, (n >= ev[0]));
      exp_bus = pack(4'b0111, 3'd0, 14'd0);
      tag = "R8 idle nop";
      if (n == ev[1])  begin exp_bus = pack(4'b0010, 3'd0, 14'h0400); tag = "R3 first precharge"; end
      if (n == ev[2])  begin exp_bus = pack(4'b0000, 3'd2, e2); tag = "R4 R9 load emr2"; end
      if (n == ev[3])  begin exp_bus = pack(4'b0000, 3'd3, e3); tag = "R4 R9 load emr3"; end
      if (n == ev[4])  begin exp_bus = pack(4'b0000, 3'd1, emr & ~14'h0381); tag = "R4 R5 load emr dll on"; end
      if (n == ev[5])  begin exp_bus = pack(4'b0000, 3'd0, mr | 14'h0100); tag = "R6 mr dll reset"; end
      if (n == ev[6])  begin exp_bus = pack(4'b0010, 3'd0, 14'h0400); tag = "R7 second precharge"; end
      if (n == ev[7])  begin exp_bus = pack(4'b0001, 3'd0, 14'd0); tag = "R7 refresh one"; end
      if (n == ev[8])  begin exp_bus = pack(4'b0001, 3'd0, 14'd0); tag = "R7 refresh two"; end
      if (n == ev[9])  begin exp_bus = pack(4'b0000, 3'd0, mr & ~14'h0100); tag = "R6 mr dll reset clear"; end
      if (n == ev[10]) begin exp_bus = pack(4'b0000, 3'd1, (emr & ~14'h0381) | 14'h0380); tag = "R5 ocd default"; end
      if (n == ev[11]) begin exp_bus = pack(4'b0000, 3'd1, emr & ~14'h0381); tag = "R5 ocd exit"; end
      act_bus = pack({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, ddr_ba, ddr_addr);
      chk(act_bus == exp_bus, tag, act_bus, exp_bus);
      chk(init_done == (n >= ev[12]), "R10 init_done", init_done, (n >= ev[12]));
      chk(read_ok == (n >= read_at), "R11 read_ok", read_ok, (n >= read_at));
    end
  endtask

  initial begin
    int gap[12];
    rst_n = 1'b0;
    mr_code = '0; emr_code = '0; emr2_code = '0; emr3_code = '0;
    gap[0] = cyc_of(T_CKE);
    gap[1] = cyc_of(T_RPA);
    for (int k = 2; k <= 5; k++) gap[k] = cyc_of(T_MRD);
    gap[6] = cyc_of(T_RPA);
    gap[7] = cyc_of(T_RFC);
    gap[8] = cyc_of(T_RFC);
    for (int k = 9; k <= 11; k++) gap[k] = cyc_of(T_MRD);
    ev[0] = cyc_of(T_PWR);
    for (int k = 1; k <= 12; k++) ev[k] = ev[k-1] + gap[k-1];
    read_at = (ev[5] + LOCK > ev[12]) ? ev[5] + LOCK : ev[12];
    last_n = read_at + 20;

    run(14'h0632, 14'h1385, 14'h0080, 14'h0000, 0);
    run(14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, ev[6] + 1);
    run(14'h0000, 14'h0000, 14'h2AAA, 14'h1555, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule